// File: doc/BRIEF.md
# DMA Request Handshake Controller

This block raises a DMA request for one data endpoint chosen by software and takes it down again under the acknowledge that the external DMA controller returns. A single 16-bit control word sets three things: the request policy, a master enable, and a 4-bit endpoint code. The block watches one "buffer ready" flag per data endpoint. That flag means the buffer has room for an IN endpoint and holds data for an OUT endpoint.

The acknowledge input `dack` is active low and idles high. It passes through a two-stage synchroniser before the block uses it. The block supports two policies. In streaming mode the request follows enable and ready directly. In single-word mode the request is only raised while the synchronised acknowledge is high. In both modes a low acknowledge pulls the request down, and the request is not raised again until the acknowledge returns high. Clearing the enable bit ends a transfer at once. While a request is active, the block refuses to move the endpoint selector and records the attempt in a sticky error flag.

Top module: `dma_req_ctrl`

## Requirements
- R1: During and after reset, `dreq` and `sel_err` are 0 and `reg_rdata` reads 16'h0000.
- R2: The control word has the policy bit at bit 15 (0 = streaming, 1 = single-word), the enable at bit 8 and the endpoint code at bits 3:0. All other bits read 0 and ignore writes. `reg_rdata` shows a write from the clock edge that accepts it.
- R3: `dreq` is a registered output. In streaming mode it is 1 when enable is set and the selected endpoint's ready flag is 1. A write that sets enable raises `dreq` on the second edge. A ready flag that falls lowers `dreq` on the next edge.
- R4: In single-word mode, `dreq` is only raised when the synchronised `dack` is also high. A `dack` that rises while the other conditions hold raises `dreq` on the third edge.
- R5: Endpoint codes 1 to 5 select ready bit code−1. Codes 0 and 6 to 15 select no endpoint, and `dreq` stays 0.
- R6: When `dack` falls while `dreq` is 1, `dreq` is still 1 after the second edge and is 0 after the third edge.
- R7: Once lowered by `dack`, `dreq` stays 0 for as long as `dack` stays low, in either mode. After `dack` rises, the conditions are evaluated again and `dreq` can return on the third edge.
- R8: A write with bit 8 = 0 drops `dreq` at the edge of that write.
- R9: A write while `dreq` is 1 that carries a different endpoint code leaves the code unchanged and sets `sel_err`. The other fields of that write still take effect. `sel_err` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 16 | Control word write data |
| reg_rdata | output | 16 | Control word read-back |
| ep_ready | input | 5 | Buffer ready per endpoint, bit i is endpoint i+1 |
| dack | input | 1 | Acknowledge from the DMA controller, active low, asynchronous |
| dreq | output | 1 | DMA request |
| sel_err | output | 1 | Sticky flag for a refused selector change |

## Verification
The block has three different latencies. A register write is visible on read-back after its own edge, and `dreq` answers it one edge later. A change on `ep_ready` reaches `dreq` at the next edge. A change on `dack` needs three edges because of the two synchroniser stages. The bench drives every input on the falling edge and samples on the falling edge after an exact number of rising edges. Each latency is checked both one edge before the change is due, where the old value must still hold, and at the edge where it is due. The vector table waits four edges after each `dack` change, which settles the synchroniser, and only then writes and compares.

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl #(
  parameter int NUM_EP = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic [NUM_EP-1:0] ep_ready,
  input  logic              dack,
  output logic              dreq,
  output logic              sel_err
);
  localparam int MODE_BIT = 15;
  localparam int EN_BIT   = 8;

  logic       mode_q, en_q, dk1_q, dk2_q, blk_q;
  logic [3:0] ep_q;
  logic       sel_rdy, abort, lock, hold, dreq_nxt;

  always_comb begin
    sel_rdy = 1'b0;
    for (int i = 0; i < NUM_EP; i++)
      if (ep_q == 4'(i + 1)) sel_rdy = ep_ready[i];
  end

  assign abort    = reg_we & ~reg_wdata[EN_BIT];
  assign lock     = reg_we & dreq & (reg_wdata[3:0] != ep_q);
  assign hold     = ~dk2_q & (dreq | blk_q);
  assign dreq_nxt = en_q & sel_rdy & (~mode_q | dk2_q) & ~hold & ~abort;

  assign reg_rdata = {mode_q, 6'b0, en_q, 4'b0, ep_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      en_q    <= 1'b0;
      ep_q    <= 4'd0;
      sel_err <= 1'b0;
    end else if (reg_we) begin
      mode_q <= reg_wdata[MODE_BIT];
      en_q   <= reg_wdata[EN_BIT];
      if (lock) sel_err <= 1'b1;
      else      ep_q    <= reg_wdata[3:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dk1_q <= 1'b0;
      dk2_q <= 1'b0;
      blk_q <= 1'b0;
      dreq  <= 1'b0;
    end else begin
      dk1_q <= dack;
      dk2_q <= dk1_q;
      blk_q <= hold;
      dreq  <= dreq_nxt;
    end
  end
endmodule

// File: rtl/dma_req_ctrl_chk.sv
module dma_req_ctrl_chk #(
  parameter int NUM_EP = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [15:0]       reg_wdata,
  input logic [15:0]       reg_rdata,
  input logic [NUM_EP-1:0] ep_ready,
  input logic              dack,
  input logic              dreq,
  input logic              sel_err
);
  function automatic logic rdy_of(input logic [3:0] ep, input logic [NUM_EP-1:0] r);
    rdy_of = 1'b0;
    for (int i = 0; i < NUM_EP; i++)
      if (ep == 4'(i + 1)) rdy_of = r[i];
  endfunction

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & 16'h7EF0) == 16'h0);

  p_ready_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_of(reg_rdata[3:0], ep_ready) |=> !dreq);

  p_single_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dreq) && $past(reg_rdata[15])) |-> $past(dack, 3));

  p_no_endpoint_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dreq |-> ($past(reg_rdata[3:0]) >= 4'd1 && $past(reg_rdata[3:0]) <= 4'(NUM_EP)
              && $past(reg_rdata[8])));

  p_ack_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dreq) && !$past(dack, 3)) |-> !dreq);

  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !reg_wdata[8]) |=> !dreq);

  p_sel_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && dreq && reg_wdata[3:0] != reg_rdata[3:0])
      |=> ($stable(reg_rdata[3:0]) && sel_err));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_err |=> sel_err);
endmodule

bind dma_req_ctrl dma_req_ctrl_chk #(.NUM_EP(NUM_EP)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .ep_ready(ep_ready), .dack(dack), .dreq(dreq),
  .sel_err(sel_err)
);

// File: tb/test_dma_req_ctrl.sv
`timescale 1ns/1ps
module test_dma_req_ctrl;
  logic        clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, dack = 1'b1;
  logic [15:0] reg_wdata = 16'h0;
  logic [4:0]  ep_ready = 5'h0;
  logic [15:0] reg_rdata;
  logic        dreq, sel_err;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  dma_req_ctrl i_dma_req_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ep_ready(ep_ready), .dack(dack), .dreq(dreq),
    .sel_err(sel_err)
  );

  // {wdata, ep_ready, dack, expected dreq}
  localparam logic [22:0] VEC [12] = '{
    {16'h0101, 5'b00001, 1'b1, 1'b1},
    {16'h0103, 5'b00100, 1'b1, 1'b1},
    {16'h0103, 5'b11011, 1'b1, 1'b0},
    {16'h0105, 5'b10000, 1'b1, 1'b1},
    {16'h7EF5, 5'b11111, 1'b1, 1'b0},
    {16'h0100, 5'b11111, 1'b1, 1'b0},
    {16'h0106, 5'b11111, 1'b1, 1'b0},
    {16'hFFFF, 5'b11111, 1'b1, 1'b0},
    {16'h8102, 5'b00010, 1'b1, 1'b1},
    {16'h8102, 5'b00010, 1'b0, 1'b0},
    {16'h0102, 5'b11111, 1'b0, 1'b0},
    {16'h0104, 5'b01000, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] d);
    reg_we = 1'b1;
    reg_wdata = d;
    step(1);
    reg_we = 1'b0;
  endtask

  initial begin
    step(3);
    chk("R1 dreq", {15'b0, dreq}, 16'h0);
    chk("R1 rdata", reg_rdata, 16'h0);
    chk("R1 sel_err", {15'b0, sel_err}, 16'h0);
    rst_n = 1'b1;
    step(2);

    for (int v = 0; v < 12; v++) begin
      ep_ready = VEC[v][6:2];
      dack     = VEC[v][1];
      step(4);
      wr({reg_rdata[15:9], 1'b0, reg_rdata[7:0]});
      wr(VEC[v][22:7]);
      chk("R2 readback", reg_rdata, VEC[v][22:7] & 16'h810F);
      step(1);
      chk("R3/R4/R5/R7 vector dreq", {15'b0, dreq}, {15'b0, VEC[v][0]});
    end

    // R3 latency and ready drop
    wr(16'h0000);
    ep_ready = 5'b00001; dack = 1'b1;
    step(4);
    wr(16'h0101);
    chk("R3 not yet", {15'b0, dreq}, 16'h0);
    step(1);
    chk("R3 raised", {15'b0, dreq}, 16'h1);
    ep_ready = 5'b0;
    step(1);
    chk("R3 ready drop", {15'b0, dreq}, 16'h0);
    ep_ready = 5'b00001;
    step(1);

    // R6 / R7 acknowledge handshake
    dack = 1'b0;
    step(2);
    chk("R6 still high", {15'b0, dreq}, 16'h1);
    step(1);
    chk("R6 dropped", {15'b0, dreq}, 16'h0);
    step(6);
    chk("R7 held low", {15'b0, dreq}, 16'h0);
    dack = 1'b1;
    step(2);
    chk("R7 not yet", {15'b0, dreq}, 16'h0);
    step(1);
    chk("R7 re-raised", {15'b0, dreq}, 16'h1);

    // R9 selector lock
    wr(16'h0102);
    chk("R9 code kept", reg_rdata, 16'h0101);
    chk("R9 sel_err", {15'b0, sel_err}, 16'h1);
    chk("R9 dreq kept", {15'b0, dreq}, 16'h1);

    // R8 abort
    wr(16'h0001);
    chk("R8 abort", {15'b0, dreq}, 16'h0);
    wr(16'h0102);
    chk("R9 free change", reg_rdata, 16'h0102);
    chk("R9 sticky", {15'b0, sel_err}, 16'h1);

    // R4 single-word waits for dack high
    ep_ready = 5'b11111; dack = 1'b0;
    step(4);
    wr(16'h8103);
    step(4);
    chk("R4 blocked", {15'b0, dreq}, 16'h0);
    dack = 1'b1;
    step(2);
    chk("R4 not yet", {15'b0, dreq}, 16'h0);
    step(1);
    chk("R4 raised", {15'b0, dreq}, 16'h1);

    // R1 reset clears sticky flag
    rst_n = 1'b0;
    step(1);
    chk("R1 reset dreq", {15'b0, dreq}, 16'h0);
    chk("R1 reset err", {15'b0, sel_err}, 16'h0);
    chk("R1 reset rdata", reg_rdata, 16'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule